// File: doc/BRIEF.md
# RTC Event Interrupt Unit

This block keeps a time of day in seconds, minutes and hours, advanced by a one-clock pulse that arrives once per second. From the carries between these counters it raises six kinds of event: a second tick, a minute tick, an hour tick, a midnight rollover, an alarm match and a stopwatch expiry. Each event sets a sticky status bit. A 6-bit enable mask decides which status bits reach the single interrupt line. The line is registered, so it follows the status one clock later.

A countdown stopwatch with minute resolution runs alongside the clock. Software loads it with a signed 6-bit value. It then decrements on every minute tick until it reaches -1, where it parks. It raises its event on each minute tick at which it holds -1 after that tick. Software reaches every register through a small synchronous write / combinational read bus with a 3-bit register select:

- 0: enable mask
- 1: status, write 1 to clear
- 2: stopwatch
- 3: alarm time
- 4: current time

The stopwatch is built as a two-state machine:

- **COUNT**: the stored value is not -1. A minute tick decrements it. A minute tick while it holds 0 loads -1, raises the event and takes the *expire* transition to PARKED.
- **PARKED**: the value is -1. Every minute tick raises the event and keeps the state (the *hold* transition).

A software load takes the *load* transition. It goes to PARKED if the loaded value is all ones, and to COUNT otherwise.

Top module: `rtc_event_irq`

## Requirements
- R1: The enable register (select 0) holds six bits: bit 5 hour, bit 4 second, bit 3 day, bit 2 alarm, bit 1 minute, bit 0 stopwatch. Bits 31..6 always read 0, and all six bits are 0 after reset.
- R2: Time (select 4, and the same layout for alarm at select 3) is laid out with hours in bits 20..16, minutes in bits 13..8 and seconds in bits 5..0. Each pulse advances the seconds. Seconds and minutes wrap 59 to 0 and carry into the next counter in the same cycle, and hours wrap 23 to 0. A written field beyond its range loads 0.
- R3: Every pulse sets status bit 4. A pulse that advances the minutes sets bit 1. A pulse that advances the hours sets bit 5.
- R4: Status bit 3 is set only by the pulse that takes the hours from 23 to 0.
- R5: Status bit 2 is set by a pulse whose new time equals the alarm register. Writing the time itself never sets it.
- R6: The stopwatch (select 2, bits 5..0, two's complement) decrements by one on each minute tick while it is not -1 (0x3F). It stays at 0x3F once there, until a write loads a new value.
- R7: Status bit 0 is set on each minute tick after which the stopwatch holds -1. Enabling bit 0 while the stopwatch is parked therefore raises the interrupt after the next minute tick, and a pulse that is not a minute tick leaves bit 0 alone.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. An event in the same cycle as the clear wins. The enable mask never changes the status bits.
- R9: `irq` equals the OR of (status AND enable) as it stood one clock earlier.
- R10: After reset the time is 00:00:00, the alarm is 0, the stopwatch holds 0x3F, and status and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-clock pulse per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong counter value shows up in two places:

- The time readback is wrong as soon as the pulse that produced it has passed.
- The status bits are wrong on the pulse that should have carried; this is usually the first sign of a broken carry chain, such as a late minute or a missed midnight.

A stopwatch whose state machine parks too early or too late is visible one minute tick later, in two ways: the value it reads back, and whether status bit 0 is set. A mistake in the mask or status path shows on `irq` exactly one clock after the status changes. The bench therefore samples the line both at the clock where it must still be low and at the clock where it must be high.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
    // status / enable bit positions
    localparam int EV_SW   = 0;
    localparam int EV_MIN  = 1;
    localparam int EV_ALM  = 2;
    localparam int EV_DAY  = 3;
    localparam int EV_SEC  = 4;
    localparam int EV_HR   = 5;
    localparam int NUM_EV  = 6;

    // register selects
    localparam logic [2:0] SEL_EN   = 3'd0;
    localparam logic [2:0] SEL_ST   = 3'd1;
    localparam logic [2:0] SEL_SW   = 3'd2;
    localparam logic [2:0] SEL_ALM  = 3'd3;
    localparam logic [2:0] SEL_TIME = 3'd4;

    // time field positions
    localparam int HR_LSB  = 16;
    localparam int MIN_LSB = 8;
    localparam int SEC_LSB = 0;

    typedef enum logic {SW_COUNT, SW_PARKED} sw_state_e;
endpackage

// File: rtl/rtc_time_base.sv
module rtc_time_base #(
    parameter int SEC_W   = 6,
    parameter int HR_W    = 5,
    parameter int SEC_MAX = 59,
    parameter int HR_MAX  = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             set_i,
    input  logic [HR_W-1:0]  set_hr_i,
    input  logic [SEC_W-1:0] set_min_i,
    input  logic [SEC_W-1:0] set_sec_i,
    input  logic [HR_W-1:0]  alm_hr_i,
    input  logic [SEC_W-1:0] alm_min_i,
    input  logic [SEC_W-1:0] alm_sec_i,
    output logic [HR_W-1:0]  hr_o,
    output logic [SEC_W-1:0] min_o,
    output logic [SEC_W-1:0] sec_o,
    output logic             ev_sec_o,
    output logic             ev_min_o,
    output logic             ev_hr_o,
    output logic             ev_day_o,
    output logic             ev_alm_o
);
    localparam logic [SEC_W-1:0] SMAX = SEC_W'(SEC_MAX);
    localparam logic [HR_W-1:0]  HMAX = HR_W'(HR_MAX);

    logic [HR_W-1:0]  hr_q, hr_d;
    logic [SEC_W-1:0] min_q, min_d, sec_q, sec_d;
    logic             adv, sec_wrap, min_wrap, hr_wrap;

    assign adv      = tick_i && !set_i;
    assign sec_wrap = (sec_q == SMAX);
    assign min_wrap = (min_q == SMAX);
    assign hr_wrap  = (hr_q == HMAX);

    always_comb begin
        hr_d  = hr_q;
        min_d = min_q;
        sec_d = sec_q;
        if (set_i) begin
            sec_d = (set_sec_i > SMAX) ? '0 : set_sec_i;
            min_d = (set_min_i > SMAX) ? '0 : set_min_i;
            hr_d  = (set_hr_i  > HMAX) ? '0 : set_hr_i;
        end else if (adv) begin
            sec_d = sec_wrap ? '0 : sec_q + 1'b1;
            if (sec_wrap) begin
                min_d = min_wrap ? '0 : min_q + 1'b1;
                if (min_wrap) begin
                    hr_d = hr_wrap ? '0 : hr_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_q  <= '0;
            min_q <= '0;
            sec_q <= '0;
        end else begin
            hr_q  <= hr_d;
            min_q <= min_d;
            sec_q <= sec_d;
        end
    end

    assign ev_sec_o = adv;
    assign ev_min_o = adv && sec_wrap;
    assign ev_hr_o  = adv && sec_wrap && min_wrap;
    assign ev_day_o = adv && sec_wrap && min_wrap && hr_wrap;
    assign ev_alm_o = adv && (hr_d == alm_hr_i) && (min_d == alm_min_i) && (sec_d == alm_sec_i);

    assign hr_o  = hr_q;
    assign min_o = min_q;
    assign sec_o = sec_q;

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n) sec_q <= SMAX);
    // R2
    min_range_chk: assert property (@(posedge clk) disable iff (!rst_n) min_q <= SMAX);
    // R2
    hr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hr_q <= HMAX);
    // R4
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_day_o |=> (hr_q == '0) && (min_q == '0) && (sec_q == '0));
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
    import rtc_evt_pkg::*;
#(
    parameter int SW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            min_tick_i,
    input  logic            load_i,
    input  logic [SW_W-1:0] load_val_i,
    output logic [SW_W-1:0] val_o,
    output logic            ev_o
);
    sw_state_e       state_q, state_d;
    logic [SW_W-1:0] val_q, val_d;

    always_comb begin
        state_d = state_q;
        val_d   = val_q;
        ev_o    = 1'b0;
        if (load_i) begin
            val_d   = load_val_i;
            state_d = (&load_val_i) ? SW_PARKED : SW_COUNT;
        end else if (min_tick_i) begin
            unique case (state_q)
                SW_COUNT: begin
                    if (val_q == '0) begin
                        val_d   = '1;
                        state_d = SW_PARKED;
                        ev_o    = 1'b1;
                    end else begin
                        val_d = val_q - 1'b1;
                    end
                end
                SW_PARKED: begin
                    ev_o = 1'b1;
                end
                default: state_d = SW_PARKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_PARKED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '1;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    // R6
    parked_value_chk: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SW_PARKED) |-> (&val_q));
    // R6
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SW_PARKED && min_tick_i && !load_i) |=> $stable(val_q));
    // R7
    expire_value_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_o |=> (&val_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
    parameter int NUM_EV = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              en_wr_i,
    input  logic              st_wr_i,
    input  logic [NUM_EV-1:0] wdata_i,
    output logic [NUM_EV-1:0] en_o,
    output logic [NUM_EV-1:0] st_o,
    output logic              irq_o
);
    logic [NUM_EV-1:0] en_q, st_q, clr;
    logic              irq_q;

    assign clr = st_wr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (en_wr_i) en_q <= wdata_i;
            st_q  <= (st_q & ~clr) | ev_i;
            irq_q <= |(st_q & en_q);
        end
    end

    assign en_o  = en_q;
    assign st_o  = st_q;
    assign irq_o = irq_q;

    // R8
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (ev_i != '0) |=> ((st_q & $past(ev_i)) == $past(ev_i)));
    // R8
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) (!st_wr_i && ev_i == '0) |=> $stable(st_q));
    // R9
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) (en_q == '0) |=> !irq_q);
    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_q == '0) |=> !irq_q);
endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq
    import rtc_evt_pkg::*;
#(
    parameter int SEC_W = 6,
    parameter int HR_W  = 5,
    parameter int SW_W  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [HR_W-1:0]   hr, alm_hr;
    logic [SEC_W-1:0]  min, sec, alm_min, alm_sec;
    logic [SW_W-1:0]   sw_val;
    logic [NUM_EV-1:0] ev, en, st;
    logic              ev_sec, ev_min, ev_hr, ev_day, ev_alm, ev_sw;
    logic              wr_time, wr_alm, wr_sw, wr_en, wr_st;
    logic              unused_wdata;

    assign wr_en   = reg_wr && (reg_addr == SEL_EN);
    assign wr_st   = reg_wr && (reg_addr == SEL_ST);
    assign wr_sw   = reg_wr && (reg_addr == SEL_SW);
    assign wr_alm  = reg_wr && (reg_addr == SEL_ALM);
    assign wr_time = reg_wr && (reg_addr == SEL_TIME);
    assign unused_wdata = ^{reg_wdata[31:21], reg_wdata[15:14], reg_wdata[7:6]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_hr  <= '0;
            alm_min <= '0;
            alm_sec <= '0;
        end else if (wr_alm) begin
            alm_hr  <= reg_wdata[HR_LSB +: HR_W];
            alm_min <= reg_wdata[MIN_LSB +: SEC_W];
            alm_sec <= reg_wdata[SEC_LSB +: SEC_W];
        end
    end

    rtc_time_base #(.SEC_W(SEC_W), .HR_W(HR_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_1hz),
        .set_i    (wr_time),
        .set_hr_i (reg_wdata[HR_LSB +: HR_W]),
        .set_min_i(reg_wdata[MIN_LSB +: SEC_W]),
        .set_sec_i(reg_wdata[SEC_LSB +: SEC_W]),
        .alm_hr_i (alm_hr),
        .alm_min_i(alm_min),
        .alm_sec_i(alm_sec),
        .hr_o     (hr),
        .min_o    (min),
        .sec_o    (sec),
        .ev_sec_o (ev_sec),
        .ev_min_o (ev_min),
        .ev_hr_o  (ev_hr),
        .ev_day_o (ev_day),
        .ev_alm_o (ev_alm)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_tick_i(ev_min),
        .load_i    (wr_sw),
        .load_val_i(reg_wdata[SW_W-1:0]),
        .val_o     (sw_val),
        .ev_o      (ev_sw)
    );

    always_comb begin
        ev         = '0;
        ev[EV_SW]  = ev_sw;
        ev[EV_MIN] = ev_min;
        ev[EV_ALM] = ev_alm;
        ev[EV_DAY] = ev_day;
        ev[EV_SEC] = ev_sec;
        ev[EV_HR]  = ev_hr;
    end

    rtc_irq_ctrl #(.NUM_EV(NUM_EV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .en_wr_i(wr_en),
        .st_wr_i(wr_st),
        .wdata_i(reg_wdata[NUM_EV-1:0]),
        .en_o   (en),
        .st_o   (st),
        .irq_o  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_EN:   reg_rdata[NUM_EV-1:0] = en;
            SEL_ST:   reg_rdata[NUM_EV-1:0] = st;
            SEL_SW:   reg_rdata[SW_W-1:0]   = sw_val;
            SEL_ALM: begin
                reg_rdata[HR_LSB +: HR_W]   = alm_hr;
                reg_rdata[MIN_LSB +: SEC_W] = alm_min;
                reg_rdata[SEC_LSB +: SEC_W] = alm_sec;
            end
            SEL_TIME: begin
                reg_rdata[HR_LSB +: HR_W]   = hr;
                reg_rdata[MIN_LSB +: SEC_W] = min;
                reg_rdata[SEC_LSB +: SEC_W] = sec;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R1
    en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == SEL_EN) |-> (reg_rdata[31:NUM_EV] == '0));
    // R3
    sec_event_chk: assert property (@(posedge clk) disable iff (!rst_n) (tick_1hz && !wr_time) |=> st[EV_SEC]);
endmodule

// File: tb/tb_rtc_event_irq.sv
module tb_rtc_event_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    rtc_event_irq dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [2:0] A_EN = 3'd0, A_ST = 3'd1, A_SW = 3'd2, A_ALM = 3'd3, A_TIME = 3'd4;

    // start time, time after one pulse, expected status (hr,sec,day,alm,min,sw = bits 5..0)
    localparam logic [31:0] T_START [7] = '{32'h000000, 32'h00003B, 32'h003B3B, 32'h173B3B,
                                            32'h0B3B3B, 32'h173A3B, 32'h0C001E};
    localparam logic [31:0] T_END   [7] = '{32'h000001, 32'h000100, 32'h010000, 32'h000000,
                                            32'h0C0000, 32'h173B00, 32'h0C001F};
    localparam logic [31:0] T_ST    [7] = '{32'h10, 32'h12, 32'h32, 32'h3A, 32'h36, 32'h12, 32'h10};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic reset_checks(input string tag);
        rd(A_EN, rv);   check(rv == 32'h0,  {tag, " R1 enable reset"}, rv, 32'h0);
        rd(A_ST, rv);   check(rv == 32'h0,  {tag, " R10 status reset"}, rv, 32'h0);
        rd(A_TIME, rv); check(rv == 32'h0,  {tag, " R10 time reset"}, rv, 32'h0);
        rd(A_SW, rv);   check(rv == 32'h3F, {tag, " R10 stopwatch reset"}, rv, 32'h3F);
        check(irq == 1'b0, {tag, " R10 irq reset"}, 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("start");

        wr(A_ALM, 32'h0C0000);
        wr(A_SW, 32'd20);
        for (int i = 0; i < 7; i++) begin
            wr(A_ST, 32'h3F);
            wr(A_TIME, T_START[i]);
            pulse();
            rd(A_ST, rv);   check(rv == T_ST[i],  "R3 R4 R5 status vector", rv, T_ST[i]);
            rd(A_TIME, rv); check(rv == T_END[i], "R2 time vector", rv, T_END[i]);
            @(negedge clk);
            check(irq == 1'b0, "R8 masked irq vector", 32'(irq), 32'h0);
        end
        rd(A_SW, rv); check(rv == 32'd15, "R6 stopwatch countdown", rv, 32'd15);

        // enable register width and irq latency
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, rv); check(rv == 32'h3F, "R1 enable upper bits zero", rv, 32'h3F);
        check(irq == 1'b0, "R9 irq one clock late", 32'(irq), 32'h0);
        @(negedge clk);
        check(irq == 1'b1, "R9 irq asserted", 32'(irq), 32'h1);
        wr(A_EN, 32'h0);
        @(negedge clk);
        check(irq == 1'b0, "R9 irq dropped", 32'(irq), 32'h0);

        // write-one-to-clear
        wr(A_ST, 32'h01);
        rd(A_ST, rv); check(rv == 32'h10, "R8 write zero keeps bit", rv, 32'h10);
        wr(A_ST, 32'h10);
        rd(A_ST, rv); check(rv == 32'h00, "R8 write one clears", rv, 32'h0);

        // event beats clear in the same cycle
        reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h10; tick_1hz = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_1hz = 1'b0;
        rd(A_ST, rv); check(rv == 32'h10, "R8 set wins over clear", rv, 32'h10);

        // stopwatch reaching -1 and parking
        wr(A_SW, 32'd1);
        wr(A_TIME, 32'h00003B);
        wr(A_ST, 32'h3F);
        pulse();
        rd(A_SW, rv); check(rv == 32'h00, "R6 stopwatch 1 to 0", rv, 32'h0);
        rd(A_ST, rv); check(rv == 32'h12, "R7 no expiry at 0", rv, 32'h12);
        wr(A_TIME, 32'h00013B);
        wr(A_ST, 32'h3F);
        pulse();
        rd(A_SW, rv); check(rv == 32'h3F, "R6 stopwatch 0 to -1", rv, 32'h3F);
        rd(A_ST, rv); check(rv == 32'h13, "R7 expiry status", rv, 32'h13);
        wr(A_TIME, 32'h00023B);
        pulse();
        rd(A_SW, rv); check(rv == 32'h3F, "R6 stopwatch parked", rv, 32'h3F);

        // enabling while parked fires on the next minute tick
        wr(A_ST, 32'h3F);
        wr(A_EN, 32'h01);
        @(negedge clk);
        check(irq == 1'b0, "R7 no irq before minute tick", 32'(irq), 32'h0);
        wr(A_TIME, 32'h00033B);
        pulse();
        check(irq == 1'b0, "R9 irq not yet at status edge", 32'(irq), 32'h0);
        @(negedge clk);
        check(irq == 1'b1, "R7 parked stopwatch irq", 32'(irq), 32'h1);

        // second tick while parked leaves bit 0 clear and masked
        wr(A_ST, 32'h3F);
        wr(A_TIME, 32'h000A0A);
        pulse();
        rd(A_ST, rv); check(rv == 32'h10, "R7 no expiry without minute", rv, 32'h10);
        @(negedge clk);
        check(irq == 1'b0, "R8 second masked", 32'(irq), 32'h0);

        // out-of-range time write and alarm readback
        wr(A_TIME, 32'h1F3F3F);
        rd(A_TIME, rv); check(rv == 32'h0, "R2 out of range loads zero", rv, 32'h0);
        rd(A_ALM, rv);  check(rv == 32'h0C0000, "R5 alarm readback", rv, 32'h0C0000);

        // reset again
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("mid");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule